// File: doc/BRIEF.md
# Interrupt Entry and Return Unit

This block sits beside a processor's fetch stage and decides, on each instruction boundary, whether an external interrupt request redirects the instruction stream to a fixed handler address. When it does, it copies the resume address and the live processor status word into two shadow registers. It also clears the interrupt-enable bit of the live status word, so the same request cannot re-enter straight away.

A return-from-interrupt strobe reverses the entry. The live status word is reloaded from the saved-status shadow, which brings back the interrupt-enable state the interrupted program had. The fetch stage is redirected to the saved address. Software may rewrite the live status word through a write port. Setting the enable bit inside a handler allows a second entry. That entry overwrites both shadow registers, so a handler that permits nesting must first copy them elsewhere.

The redirect outputs and the taken pulse are combinational in the acceptance cycle. The status word and the shadow registers change at the clock edge that ends that cycle.

Top module: `exc_entry_unit`

## Requirements
- R1: While `rst_ni` is low, `ps_o` equals `PS_RESET` (default 0x00), `epc_o` and `estat_o` are 0, and `redirect_o` and `taken_o` are 0.
- R2: `taken_o` is 1 in a cycle exactly when `irq_i`, `boundary_i` and `ps_o[IE_BIT]` (bit 0 by default) are all 1 and `rti_i` is 0. It is never 1 for two cycles from a single boundary.
- R3: In a cycle with `taken_o` high, `redirect_o` is 1 and `redirect_pc_o` equals `HANDLER_ADDR` (default 0x20).
- R4: After an accepting cycle, `epc_o` holds the `pc_next_i` value that was present in that cycle, which is the address of the instruction that would have run next.
- R5: After an accepting cycle, `estat_o` holds the `ps_o` value from before the edge.
- R6: After an accepting cycle, `ps_o[IE_BIT]` is 0 and every other bit of `ps_o` is unchanged.
- R7: In a cycle with `rti_i` high, `redirect_o` is 1 and `redirect_pc_o` equals `epc_o`. After the edge, `ps_o` equals the prior `estat_o`, and `epc_o` and `estat_o` are unchanged.
- R8: When `rti_i` coincides with a request that would otherwise be accepted, only the return happens and `taken_o` stays 0. The request is judged at the next boundary against the restored enable bit.
- R9: With `ps_we_i` high, `ps_o` takes `ps_wdata_i` at the edge. The write is ignored in a cycle that accepts an interrupt or carries `rti_i`.
- R10: A second acceptance overwrites `epc_o` and `estat_o` with the new resume address and status word. No earlier context is kept.
- R11: Without an acceptance or return, `epc_o` and `estat_o` keep their values, and `redirect_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Interrupt request level |
| boundary_i | input | 1 | High in a cycle that ends an instruction |
| pc_next_i | input | XLEN | Address of the instruction that would run next |
| rti_i | input | 1 | Return-from-interrupt command |
| ps_we_i | input | 1 | Software write enable for the status word |
| ps_wdata_i | input | PS_W | Software write data for the status word |
| redirect_o | output | 1 | Next PC is to be taken from redirect_pc_o |
| redirect_pc_o | output | XLEN | Redirect target |
| taken_o | output | 1 | Interrupt accepted this cycle |
| ps_o | output | PS_W | Live processor status word |
| epc_o | output | XLEN | Saved resume address |
| estat_o | output | PS_W | Saved status word |

## Verification
The assertions check every cycle that acceptance needs a request, a boundary and a set enable bit, and that it never coincides with a return. They also check that acceptance redirects to the handler, captures both shadows and clears the enable bit, and that a return restores the status word while the shadows stay still otherwise. Some behaviour depends on a sequence of events rather than on adjacent cycles, and only the bench's scenarios show it. That covers a request held across the return that re-enables it and then being taken at the following boundary, a nested entry that discards the first context, and software writes lost to a simultaneous entry or return.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  typedef enum logic [1:0] {
    REDIR_NONE    = 2'd0,
    REDIR_HANDLER = 2'd1,
    REDIR_RETURN  = 2'd2
  } redir_e;
endpackage

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter
  import exc_pkg::*;
(
  input  logic   irq_i,
  input  logic   boundary_i,
  input  logic   ie_i,
  input  logic   rti_i,
  output redir_e cause_o,
  output logic   take_o
);
  // return has priority; a pending request waits for the restored enable
  always_comb begin
    cause_o = REDIR_NONE;
    take_o  = 1'b0;
    if (rti_i) begin
      cause_o = REDIR_RETURN;
    end else if (irq_i && ie_i && boundary_i) begin
      cause_o = REDIR_HANDLER;
      take_o  = 1'b1;
    end
  end
endmodule

// File: rtl/exc_shadow.sv
`timescale 1ns/1ps
module exc_shadow #(
  parameter int XLEN = 32,
  parameter int PS_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            capture_i,
  input  logic [XLEN-1:0] pc_next_i,
  input  logic [PS_W-1:0] ps_i,
  output logic [XLEN-1:0] epc_o,
  output logic [PS_W-1:0] estat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o   <= '0;
      estat_o <= '0;
    end else if (capture_i) begin
      epc_o   <= pc_next_i;
      estat_o <= ps_i;
    end
  end
endmodule

// File: rtl/exc_status.sv
`timescale 1ns/1ps
module exc_status #(
  parameter int              PS_W     = 8,
  parameter int              IE_BIT   = 0,
  parameter logic [PS_W-1:0] PS_RESET = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            rti_i,
  input  logic            we_i,
  input  logic [PS_W-1:0] wdata_i,
  input  logic [PS_W-1:0] estat_i,
  output logic [PS_W-1:0] ps_o
);
  localparam logic [PS_W-1:0] IE_MASK = PS_W'(1) << IE_BIT;

  logic [PS_W-1:0] ps_d;

  // priority: return, entry, software write
  always_comb begin
    ps_d = ps_o;
    if (rti_i)       ps_d = estat_i;
    else if (take_i) ps_d = ps_o & ~IE_MASK;
    else if (we_i)   ps_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ps_o <= PS_RESET;
    else         ps_o <= ps_d;
  end
endmodule

// File: rtl/exc_entry_unit.sv
`timescale 1ns/1ps
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int               XLEN         = 32,
  parameter int               PS_W         = 8,
  parameter int               IE_BIT       = 0,
  parameter logic [XLEN-1:0]  HANDLER_ADDR = 32'h0000_0020,
  parameter logic [PS_W-1:0]  PS_RESET     = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            irq_i,
  input  logic            boundary_i,
  input  logic [XLEN-1:0] pc_next_i,
  input  logic            rti_i,
  input  logic            ps_we_i,
  input  logic [PS_W-1:0] ps_wdata_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            taken_o,
  output logic [PS_W-1:0] ps_o,
  output logic [XLEN-1:0] epc_o,
  output logic [PS_W-1:0] estat_o
);
  redir_e cause;
  logic   take;

  exc_arbiter i_arb (
    .irq_i      (irq_i),
    .boundary_i (boundary_i),
    .ie_i       (ps_o[IE_BIT]),
    .rti_i      (rti_i),
    .cause_o    (cause),
    .take_o     (take)
  );

  exc_shadow #(.XLEN(XLEN), .PS_W(PS_W)) i_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (take),
    .pc_next_i (pc_next_i),
    .ps_i      (ps_o),
    .epc_o     (epc_o),
    .estat_o   (estat_o)
  );

  exc_status #(.PS_W(PS_W), .IE_BIT(IE_BIT), .PS_RESET(PS_RESET)) i_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .rti_i   (rti_i),
    .we_i    (ps_we_i),
    .wdata_i (ps_wdata_i),
    .estat_i (estat_o),
    .ps_o    (ps_o)
  );

  always_comb begin
    unique case (cause)
      REDIR_HANDLER: redirect_pc_o = HANDLER_ADDR;
      REDIR_RETURN:  redirect_pc_o = epc_o;
      default:       redirect_pc_o = '0;
    endcase
  end

  assign redirect_o = (cause != REDIR_NONE);
  assign taken_o    = take;
endmodule

// File: rtl/exc_entry_chk.sv
`timescale 1ns/1ps
module exc_entry_chk #(
  parameter int              XLEN         = 32,
  parameter int              PS_W         = 8,
  parameter int              IE_BIT       = 0,
  parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h0000_0020,
  parameter logic [PS_W-1:0] PS_RESET     = '0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            irq_i,
  input logic            boundary_i,
  input logic [XLEN-1:0] pc_next_i,
  input logic            rti_i,
  input logic            redirect_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic            taken_o,
  input logic [PS_W-1:0] ps_o,
  input logic [XLEN-1:0] epc_o,
  input logic [PS_W-1:0] estat_o
);
  localparam logic [PS_W-1:0] IE_MASK = PS_W'(1) << IE_BIT;

  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_state: assert (ps_o == PS_RESET && epc_o == '0 && estat_o == '0);
    end
  end

  a_r2_take_needs_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (irq_i && boundary_i && ps_o[IE_BIT]));
  a_r8_return_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rti_i |-> !taken_o);
  a_r3_handler_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (redirect_o && redirect_pc_o == HANDLER_ADDR));
  a_r4_epc_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |=> epc_o == $past(pc_next_i));
  a_r5_estat_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |=> estat_o == $past(ps_o));
  a_r6_ie_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |=> ((ps_o & ~IE_MASK) == ($past(ps_o) & ~IE_MASK)) && !ps_o[IE_BIT]);
  a_r7_return_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rti_i |=> (ps_o == $past(estat_o)) && $stable(epc_o) && $stable(estat_o));
  a_r7_return_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rti_i |-> (redirect_o && redirect_pc_o == epc_o));
  a_r11_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |=> $stable(epc_o) && $stable(estat_o));
  a_r11_no_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!taken_o && !rti_i) |-> !redirect_o);
endmodule

bind exc_entry_unit exc_entry_chk #(
  .XLEN(XLEN), .PS_W(PS_W), .IE_BIT(IE_BIT),
  .HANDLER_ADDR(HANDLER_ADDR), .PS_RESET(PS_RESET)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .boundary_i(boundary_i),
  .pc_next_i(pc_next_i), .rti_i(rti_i), .redirect_o(redirect_o),
  .redirect_pc_o(redirect_pc_o), .taken_o(taken_o), .ps_o(ps_o),
  .epc_o(epc_o), .estat_o(estat_o)
);

// File: tb/test_exc_entry_unit.sv
`timescale 1ns/1ps
module test_exc_entry_unit;
  localparam logic [31:0] HANDLER = 32'h0000_0020;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        irq_i = 1'b0, boundary_i = 1'b0, rti_i = 1'b0, ps_we_i = 1'b0;
  logic [31:0] pc_next_i = '0;
  logic [7:0]  ps_wdata_i = '0;
  logic        redirect_o, taken_o;
  logic [31:0] redirect_pc_o, epc_o;
  logic [7:0]  ps_o, estat_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  exc_entry_unit i_exc_entry_unit (
    .clk_i, .rst_ni, .irq_i, .boundary_i, .pc_next_i, .rti_i, .ps_we_i,
    .ps_wdata_i, .redirect_o, .redirect_pc_o, .taken_o, .ps_o, .epc_o, .estat_o
  );

  typedef struct {
    string       tag;
    logic        taken;
    logic        redir;
    logic [31:0] rpc;
    logic [7:0]  ps;
    logic [31:0] epc;
    logic [7:0]  estat;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0, n_bad = 0;
  bit   done = 0;

  // bench's own model of the status word and shadows
  logic [7:0]  m_ps = 8'h00, m_estat = 8'h00;
  logic [31:0] m_epc = '0;

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic irq, logic bnd, logic rti,
                      logic we, logic [7:0] wd, logic [31:0] pc);
    exp_t e;
    @(negedge clk_i);
    irq_i = irq; boundary_i = bnd; rti_i = rti; ps_we_i = we;
    ps_wdata_i = wd; pc_next_i = pc;
    e.tag = tag; e.taken = 1'b0; e.redir = 1'b0; e.rpc = '0;
    if (rti) begin
      e.redir = 1'b1; e.rpc = m_epc;
      m_ps = m_estat;
    end else if (irq && bnd && m_ps[0]) begin
      e.taken = 1'b1; e.redir = 1'b1; e.rpc = HANDLER;
      m_epc = pc; m_estat = m_ps; m_ps = m_ps & 8'hFE;
    end else if (we) begin
      m_ps = wd;
    end
    e.ps = m_ps; e.epc = m_epc; e.estat = m_estat;
    q.push_back(e);
  endtask

  // monitor: combinational outputs mid-cycle, state after the edge
  initial begin
    forever begin
      exp_t e;
      @(negedge clk_i);
      #5;
      if (q.size() != 0) begin
        e = q.pop_front();
        cmp(e.tag, "taken_o", 32'(taken_o), 32'(e.taken));
        cmp(e.tag, "redirect_o", 32'(redirect_o), 32'(e.redir));
        if (e.redir) cmp(e.tag, "redirect_pc_o", redirect_pc_o, e.rpc);
        @(posedge clk_i);
        #2;
        cmp(e.tag, "ps_o", 32'(ps_o), 32'(e.ps));
        cmp(e.tag, "epc_o", epc_o, e.epc);
        cmp(e.tag, "estat_o", 32'(estat_o), 32'(e.estat));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    cmp("R1", "ps_o", 32'(ps_o), 32'h00);
    cmp("R1", "epc_o", epc_o, 32'h0);
    cmp("R1", "estat_o", 32'(estat_o), 32'h00);
    cmp("R1", "redirect_o", 32'(redirect_o), 32'h0);
    cmp("R1", "taken_o", 32'(taken_o), 32'h0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R2: request with IE=0 is not taken
    step("R2 ie_low", 1, 1, 0, 0, 8'h00, 32'h0000_0040);
    // R9: software write enables interrupts
    step("R9 sw_write", 0, 0, 0, 1, 8'h81, 32'h0000_0044);
    // R11: request without a boundary is ignored
    step("R11 no_boundary", 1, 0, 0, 0, 8'h00, 32'h0000_0048);
    step("R11 idle", 0, 1, 0, 0, 8'h00, 32'h0000_004C);
    // R3 R4 R5 R6: accepted entry
    step("R4 entry", 1, 1, 0, 0, 8'h00, 32'h0000_0100);
    // R2: held request with IE cleared is not taken again
    step("R2 masked", 1, 1, 0, 0, 8'h00, 32'h0000_0020);
    // R7: return restores status and targets saved address
    step("R7 return", 0, 0, 1, 0, 8'h00, 32'h0000_0024);
    // second entry, then R8 coincidence
    step("R6 entry2", 1, 1, 0, 0, 8'h00, 32'h0000_0200);
    step("R8 rti_vs_irq", 1, 1, 1, 0, 8'h00, 32'h0000_0028);
    step("R8 after_return", 1, 1, 0, 0, 8'h00, 32'h0000_0204);
    // R10: nesting after software re-enable with different status
    step("R9 handler_enable", 0, 0, 0, 1, 8'h83, 32'h0000_0024);
    step("R10 nested_entry", 1, 1, 0, 0, 8'h00, 32'h0000_0300);
    // R9: writes lost to entry and to return
    step("R9 write_vs_rti", 0, 0, 1, 1, 8'h55, 32'h0000_0028);
    step("R9 write_vs_entry", 1, 1, 0, 1, 8'hFF, 32'h0000_0400);
    step("R7 return2", 0, 0, 1, 0, 8'h00, 32'h0000_0024);
    step("R11 quiet", 0, 1, 0, 0, 8'h00, 32'h0000_0404);
    @(negedge clk_i);
    irq_i = 0; boundary_i = 0; rti_i = 0; ps_we_i = 0;
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule